// File: doc/BRIEF.md
# Edge-Configurable SPI Master

This block is a byte-wide serial master. Software loads one byte into the transmit register. The block then drives a serial clock and a data-out line, and it samples a data-in line. After eight bits it places the received byte in a read register. Three configuration bits set the clock timing:

- An idle-level bit sets the level the clock rests at.
- A launch-edge bit sets which clock transition moves new data onto the output.
- A late-sample bit moves the input sample from the middle of a bit to its end.

Together these bits cover all four common SPI modes. A rate field divides the system clock by 4, 16 or 64.

The timing fields and the rate field are locked while the port is enabled. To change them, software clears the enable bit, rewrites the fields, and sets enable again. A disabled port drives none of its serial lines. Two sticky flags report errors. One is set when a byte is written during a transfer. The other is set when a byte arrives before the previous one was read. A single active-low select is low during each transfer.

Top module: `spi_edge_master`

## Requirements
- R1: After synchronous reset, every register is zero. The clock output is low, both output enables are low, busy, done and both flags are low, and the config readback is 0x00.
- R2: While no transfer runs, the serial clock equals the idle-level bit (config bit 1). 0 means idle low and 1 means idle high. The level follows that bit while the port is disabled.
- R3: A transfer makes exactly 16 clock transitions. Input is captured on the transition toward active when the launch-edge bit (config bit 2) is 1, and on the transition back to idle when it is 0. The four idle-level/launch-edge pairs therefore give rising-edge capture for (0,1) and (1,0), and falling-edge capture for (0,0) and (1,1).
- R4: Data moves MSB first, eight bits per transfer. With launch-edge bit 1, the first bit is on the data-out line before the first clock transition. Busy is high from the transmit write until the end of the sixteenth half period. A one-cycle done pulse marks the load of the read register.
- R5: With the late-sample bit (config bit 3) at 0, input is sampled at the middle of each output bit time. With it at 1, input is sampled at the end of that time, which is the next launch point or the end of the transfer.
- R6: Rate field config[7:4]: 0 gives a divide by 4, so a transfer lasts 32 system clocks. 1 gives a divide by 16 (128 clocks) and 2 a divide by 64 (512 clocks). Any other value leaves the port idle, and transmit writes start nothing.
- R7: While enable (config bit 0) is 1, a config write leaves bits 7:1 unchanged and updates only enable and the flag-clear bits.
- R8: While enable is 0, both output enables are low and a transmit write starts no transfer and sets no flag.
- R9: A transmit write during a transfer sets the collision flag. The written byte is dropped and the running transfer finishes unchanged.
- R10: A received byte completing while the previous one is still unread sets the overflow flag. A read strobe in the same cycle as completion avoids the flag.
- R11: Both flags stay set until a config write carries 0 in their clear bit (bit 8 for collision, bit 9 for overflow). A 1 in that bit keeps the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Config write strobe |
| ctrl_wdata | input | 10 | Config write data: [0] enable, [1] idle level, [2] launch edge, [3] late sample, [7:4] rate, [8] keep collision, [9] keep overflow |
| tx_we | input | 1 | Transmit register write strobe |
| tx_wdata | input | 8 | Byte to send |
| rd_stb | input | 1 | Marks the received byte as read |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sck_oe | output | 1 | Drive enable for the serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Drive enable for serial data out |
| cs_n | output | 1 | Active-low select, low while busy |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a byte is received |
| rx_data | output | 8 | Last received byte |
| cfg_rd | output | 8 | Config readback, bits 7:0 |
| wcol | output | 1 | Sticky write-collision flag |
| rovf | output | 1 | Sticky receive-overflow flag |

## Verification
The bench acts as the slave. It counts clock transitions, checks the level at each capture transition, and rebuilds the MOSI byte for all four idle-level/launch-edge pairs. A design that swapped a phase would show the wrong capture direction or a shifted byte. For the late-sample case, the slave changes data at mid-bit. With this slave, end sampling returns the byte intact and mid sampling returns it shifted by one bit, so an ignored late-sample bit is caught. The bench also covers:
- the three rate codes, by measuring busy length;
- an illegal rate code that must start nothing;
- a field write while enabled, which must leave the readback unchanged;
- a collision write that must not corrupt the running byte;
- two unread receptions that must raise the overflow flag;
- flag clear versus keep.

// File: rtl/spi_edge_pkg.sv
package spi_edge_pkg;

    typedef enum logic [3:0] {
        RATE_FAST = 4'd0,
        RATE_MID  = 4'd1,
        RATE_SLOW = 4'd2
    } rate_e;

    typedef struct packed {
        logic [3:0] rate;
        logic       late_smp;
        logic       launch_ret;
        logic       idle_hi;
        logic       en;
    } port_cfg_t;

    function automatic logic rate_ok(input logic [3:0] r);
        return (r == 4'(RATE_FAST)) || (r == 4'(RATE_MID)) || (r == 4'(RATE_SLOW));
    endfunction

    function automatic int half_len(input logic [3:0] r, input int div_f,
                                    input int div_m, input int div_s);
        if (r == 4'(RATE_MID))  return div_m / 2;
        if (r == 4'(RATE_SLOW)) return div_s / 2;
        return div_f / 2;
    endfunction

endpackage

// File: rtl/spi_edge_regs.sv
module spi_edge_regs
    import spi_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [9:0] ctrl_wdata,
    input  logic       tx_we,
    input  logic       busy,
    input  logic       done,
    input  logic       rd_stb,
    output port_cfg_t  cfg,
    output logic       wcol,
    output logic       rovf
);
    logic rx_full;
    logic set_wcol;
    logic set_rovf;

    assign set_wcol = tx_we && cfg.en && busy;
    assign set_rovf = done && rx_full && !rd_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            wcol    <= 1'b0;
            rovf    <= 1'b0;
            rx_full <= 1'b0;
        end else begin
            if (ctrl_we) begin
                cfg.en <= ctrl_wdata[0];
                if (!cfg.en) cfg[7:1] <= ctrl_wdata[7:1];
            end
            if (set_wcol)                      wcol <= 1'b1;
            else if (ctrl_we && !ctrl_wdata[8]) wcol <= 1'b0;
            if (set_rovf)                      rovf <= 1'b1;
            else if (ctrl_we && !ctrl_wdata[9]) rovf <= 1'b0;
            if (done)        rx_full <= 1'b1;
            else if (rd_stb) rx_full <= 1'b0;
        end
    end

    p_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && ctrl_we) |=> (cfg[7:1] == $past(cfg[7:1])));
    p_collision_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_we && busy && cfg.en) |=> wcol);
    p_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (done && rx_full && !rd_stb) |=> rovf);
endmodule

// File: rtl/spi_edge_shifter.sv
module spi_edge_shifter
    import spi_edge_pkg::*;
#(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 64,
    parameter int NBITS    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  port_cfg_t        cfg,
    input  logic             tx_we,
    input  logic [NBITS-1:0] tx_wdata,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [NBITS-1:0] rx_data
);
    localparam int CW     = $clog2(DIV_SLOW / 2);
    localparam int HW     = $clog2(2 * NBITS + 1);
    localparam int NHALF  = 2 * NBITS;

    logic             active;
    logic [CW-1:0]    cnt;
    logic [HW-1:0]    hidx;
    logic [HW-1:0]    nxt;
    logic             phase_act;
    logic             mosi_q;
    logic [NBITS-1:0] tx_sh;
    logic [NBITS-1:0] rx_sh;
    logic [CW-1:0]    half_m1;
    logic             tick;
    logic             start;
    logic             take;

    assign half_m1 = CW'(half_len(cfg.rate, DIV_FAST, DIV_MID, DIV_SLOW) - 1);
    assign tick    = active && (cnt == half_m1);
    assign nxt     = hidx + 1'b1;
    assign start   = tx_we && cfg.en && rate_ok(cfg.rate) && !active;
    // mid sample on odd halves, late sample on the next even boundary
    assign take    = cfg.late_smp ? (!nxt[0] && (nxt >= HW'(2))) : nxt[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cnt       <= '0;
            hidx      <= '0;
            phase_act <= 1'b0;
            mosi_q    <= 1'b0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            rx_data   <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!cfg.en) begin
                active    <= 1'b0;
                phase_act <= 1'b0;
                cnt       <= '0;
            end else if (start) begin
                active    <= 1'b1;
                cnt       <= '0;
                hidx      <= '0;
                phase_act <= ~cfg.launch_ret;
                mosi_q    <= tx_wdata[NBITS-1];
                tx_sh     <= {tx_wdata[NBITS-2:0], 1'b0};
                rx_sh     <= '0;
            end else if (tick) begin
                cnt  <= '0;
                hidx <= nxt;
                if (nxt == HW'(NHALF)) begin
                    active    <= 1'b0;
                    phase_act <= 1'b0;
                    done      <= 1'b1;
                    rx_data   <= cfg.late_smp ? {rx_sh[NBITS-2:0], miso} : rx_sh;
                end else begin
                    phase_act <= nxt[0] ^ ~cfg.launch_ret;
                    if (take) rx_sh <= {rx_sh[NBITS-2:0], miso};
                    if (!nxt[0]) begin
                        mosi_q <= tx_sh[NBITS-1];
                        tx_sh  <= {tx_sh[NBITS-2:0], 1'b0};
                    end
                end
            end else if (active) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign sck  = active ? (cfg.idle_hi ^ phase_act) : cfg.idle_hi;
    assign mosi = mosi_q;
    assign busy = active;

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && tick && nxt[0]) |=> $stable(mosi_q));
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/spi_edge_master.sv
module spi_edge_master
    import spi_edge_pkg::*;
#(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 64,
    parameter int NBITS    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [9:0]       ctrl_wdata,
    input  logic             tx_we,
    input  logic [NBITS-1:0] tx_wdata,
    input  logic             rd_stb,
    input  logic             miso,
    output logic             sck,
    output logic             sck_oe,
    output logic             mosi,
    output logic             mosi_oe,
    output logic             cs_n,
    output logic             busy,
    output logic             done,
    output logic [NBITS-1:0] rx_data,
    output logic [7:0]       cfg_rd,
    output logic             wcol,
    output logic             rovf
);
    port_cfg_t cfg;

    spi_edge_regs u_regs (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tx_we(tx_we), .busy(busy), .done(done), .rd_stb(rd_stb),
        .cfg(cfg), .wcol(wcol), .rovf(rovf)
    );

    spi_edge_shifter #(
        .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW), .NBITS(NBITS)
    ) u_shift (
        .clk(clk), .rst(rst), .cfg(cfg), .tx_we(tx_we), .tx_wdata(tx_wdata),
        .miso(miso), .sck(sck), .mosi(mosi), .busy(busy), .done(done),
        .rx_data(rx_data)
    );

    assign sck_oe  = cfg.en;
    assign mosi_oe = cfg.en;
    assign cs_n    = ~busy;
    assign cfg_rd  = cfg;

    p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == cfg_rd[1]));
    p_done_ends_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    p_off_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd[0] |=> !busy);
    p_bad_rate_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rate_ok(cfg_rd[7:4])) |=> !busy);
endmodule

// File: tb/spi_edge_master_bench.sv
module spi_edge_master_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [9:0] ctrl_wdata = '0;
    logic       tx_we = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       rd_stb = 1'b0;
    logic       miso = 1'b0;
    logic       sck, sck_oe, mosi, mosi_oe, cs_n, busy, done, wcol, rovf;
    logic [7:0] rx_data, cfg_rd;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    logic watch = 1'b0;
    int   n_edges = 0;
    int   dir_err = 0;
    int   hb = 0;
    logic [7:0] mosi_got = '0;
    logic [7:0] slave_b = '0;
    logic slave_late = 1'b0;
    logic ckp_b = 1'b0;
    logic cke_b = 1'b0;

    always #2.5 clk = ~clk;

    spi_edge_master u_spi_edge_master (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .rd_stb(rd_stb), .miso(miso),
        .sck(sck), .sck_oe(sck_oe), .mosi(mosi), .mosi_oe(mosi_oe), .cs_n(cs_n),
        .busy(busy), .done(done), .rx_data(rx_data), .cfg_rd(cfg_rd),
        .wcol(wcol), .rovf(rovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slave model: counts transitions, captures MOSI, drives MISO
    always @(sck) begin
        if (watch) begin
            n_edges++;
            hb = cke_b ? n_edges : n_edges - 1;
            if (hb % 2 == 1) begin
                mosi_got = {mosi_got[6:0], mosi};
                if (sck !== (ckp_b ^ cke_b)) dir_err++;
            end
            if (!slave_late && hb % 2 == 0 && hb >= 2 && hb < 16) miso = slave_b[7 - hb/2];
            if (slave_late && hb % 2 == 1 && hb < 16) miso = slave_b[7 - (hb-1)/2];
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected done", 1, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_data == e, "R4/R5 received byte", rx_data, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic wr_ctrl(input bit en, input bit ckp, input bit cke, input bit smp,
                           input logic [3:0] rate, input logic [1:0] keep);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = {keep, rate, smp, cke, ckp, en};
        @(negedge clk);
        ctrl_we = 1'b0;
        ckp_b = cfg_rd[1];
        cke_b = cfg_rd[2];
    endtask

    task automatic reconf(input bit ckp, input bit cke, input bit smp, input logic [3:0] rate);
        wr_ctrl(1'b0, ckp, cke, smp, rate, 2'b11);
        wr_ctrl(1'b1, ckp, cke, smp, rate, 2'b11);
    endtask

    task automatic rd();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] sb, input bit late,
                        input bit x0, input logic [7:0] exp_rx, input int half,
                        input bit poke);
        int cyc;
        slave_b = sb; slave_late = late;
        miso = late ? x0 : sb[7];
        n_edges = 0; dir_err = 0; mosi_got = '0;
        @(negedge clk);
        watch = 1'b1;
        exp_q.push_back(exp_rx);
        tx_we = 1'b1; tx_wdata = tx;
        @(negedge clk);
        tx_we = 1'b0;
        cyc = 0;
        while (busy && cyc < 2000) begin
            cyc++;
            if (poke && cyc == 4) begin tx_we = 1'b1; tx_wdata = ~tx; end
            else tx_we = 1'b0;
            @(negedge clk);
        end
        tx_we = 1'b0;
        watch = 1'b0;
        chk(cyc == 16 * half, "R6 transfer length", cyc, 16 * half);
        chk(n_edges == 16, "R3 clock transitions", n_edges, 16);
        chk(dir_err == 0, "R3 capture edge direction", dir_err, 0);
        chk(mosi_got == tx, "R4 MSB-first mosi byte", mosi_got, tx);
        chk(sck == ckp_b, "R2 idle after transfer", sck, ckp_b);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sck == 1'b0 && sck_oe == 1'b0 && mosi_oe == 1'b0, "R1 outputs", {sck, sck_oe, mosi_oe}, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
        chk(wcol == 1'b0 && rovf == 1'b0, "R1 flags", {wcol, rovf}, 0);
        chk(cfg_rd == 8'h00 && rx_data == 8'h00, "R1 registers", cfg_rd, 0);

        // R8 disabled: transmit ignored
        @(negedge clk); tx_we = 1'b1; tx_wdata = 8'h77;
        @(negedge clk); tx_we = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1 && wcol == 1'b0, "R8 write while disabled", busy, 0);
        chk(sck_oe == 1'b0 && mosi_oe == 1'b0, "R8 lines undriven", {sck_oe, mosi_oe}, 0);

        // R2 idle level follows while disabled
        wr_ctrl(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 2'b11);
        chk(sck == 1'b1, "R2 idle high while disabled", sck, 1);

        // mode 0: idle low, launch on return
        reconf(1'b0, 1'b1, 1'b0, 4'd0);
        chk(sck_oe == 1'b1 && mosi_oe == 1'b1 && sck == 1'b0, "R2 enabled idle low", sck, 0);
        xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 8'h3C, 2, 1'b0); rd();
        // mode 1
        reconf(1'b0, 1'b0, 1'b0, 4'd0);
        xfer(8'h5A, 8'hC3, 1'b0, 1'b0, 8'hC3, 2, 1'b0); rd();
        // mode 2, divide by 16
        reconf(1'b1, 1'b0, 1'b0, 4'd1);
        chk(sck == 1'b1, "R2 enabled idle high", sck, 1);
        xfer(8'h96, 8'h69, 1'b0, 1'b0, 8'h69, 8, 1'b0); rd();
        // mode 3, divide by 64
        reconf(1'b1, 1'b1, 1'b0, 4'd2);
        xfer(8'hF0, 8'h0F, 1'b0, 1'b0, 8'h0F, 32, 1'b0); rd();

        // R7 lock while enabled
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 2'b11);
        chk(cfg_rd == 8'h27, "R7 fields locked", cfg_rd, 8'h27);

        // R5 late sampling with a slave that changes data at mid-bit
        reconf(1'b0, 1'b1, 1'b1, 4'd0);
        xfer(8'h33, 8'hD2, 1'b1, 1'b1, 8'hD2, 2, 1'b0); rd();
        reconf(1'b0, 1'b1, 1'b0, 4'd0);
        xfer(8'h33, 8'hD2, 1'b1, 1'b1, 8'hE9, 2, 1'b0); rd();

        // R6 illegal rate starts nothing
        reconf(1'b0, 1'b1, 1'b0, 4'd3);
        @(negedge clk); tx_we = 1'b1; tx_wdata = 8'h11;
        @(negedge clk); tx_we = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R6 illegal rate idle", busy, 0);

        // R9 collision
        reconf(1'b0, 1'b1, 1'b0, 4'd0);
        xfer(8'hC5, 8'h5C, 1'b0, 1'b0, 8'h5C, 2, 1'b1); rd();
        chk(wcol == 1'b1, "R9 collision flag", wcol, 1);
        // R11 keep vs clear
        wr_ctrl(1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 2'b11);
        chk(wcol == 1'b1, "R11 flag kept", wcol, 1);
        wr_ctrl(1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 2'b10);
        chk(wcol == 1'b0, "R11 collision cleared", wcol, 0);

        // R10 overflow
        xfer(8'h01, 8'h81, 1'b0, 1'b0, 8'h81, 2, 1'b0);
        @(negedge clk);
        chk(rovf == 1'b0, "R10 no overflow on first", rovf, 0);
        xfer(8'h02, 8'h42, 1'b0, 1'b0, 8'h42, 2, 1'b0);
        @(negedge clk);
        chk(rovf == 1'b1, "R10 overflow set", rovf, 1);
        rd();
        wr_ctrl(1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 2'b01);
        chk(rovf == 1'b0, "R11 overflow cleared", rovf, 0);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule